// File: doc/BRIEF.md
# Memory Access Ordering Guard

This block sits at the issue point of an out-of-order core, just ahead of the load and store holding buffers. Loads and stores reach it one at a time, in program order, each with its effective word address already computed. The block compares the incoming address with the addresses held in the occupied buffer entries and decides, in the same cycle, whether the access may issue or whether the instruction queue must wait.

A load is checked only against pending stores. A store is checked against pending stores and pending loads. An access is also held back when the buffer for its kind has no free slot. When an access is granted, its address is written into the lowest-numbered free slot of its buffer, and that slot number is reported. A completion strobe frees a slot. A slot whose strobe is high in the current cycle already counts as free, so a wait caused by that slot ends in the same cycle.

Top module: `mog_order_guard`

## Requirements
- R1: After reset both buffers are empty. With no request, `stall` and `grant` are 0. The first load and the first store are each granted with `grant_idx` = 0.
- R2: A load (`req_is_store` = 0) is stalled (`stall` = 1, `grant` = 0) when its address equals the address of any occupied store slot.
- R3: A stalled request that is held steady stays stalled until every conflicting slot is released. In the cycle the last conflicting slot's done strobe is high, `stall` is 0 and `grant` is 1.
- R4: A store (`req_is_store` = 1) is stalled when its address equals the address of any occupied store slot or any occupied load slot.
- R5: A load whose address matches only occupied load slots is granted. Any access whose address matches no occupied slot it is checked against, and whose buffer has room, is granted in the same cycle.
- R6: A granted access writes its address into the lowest-numbered free slot of the buffer picked by `req_is_store`, and `grant_idx` reports that slot. The slot is occupied from the next cycle on.
- R7: An access is stalled when every slot of its own buffer is occupied, even if no address matches.
- R8: Bit i of `ld_done`/`st_done` frees slot i of the load/store buffer. A slot whose strobe is high counts as free in that same cycle, both for comparison and for allocation. With no request pending, a strobe leaves `stall` and `grant` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented for issue |
| req_is_store | input | 1 | 0 = load, 1 = store |
| req_addr | input | ADDR_W (16) | Effective word address of the access |
| ld_done | input | LD_DEPTH (4) | Per-slot release strobes, load buffer |
| st_done | input | ST_DEPTH (4) | Per-slot release strobes, store buffer |
| stall | output | 1 | Hold the instruction queue this cycle |
| grant | output | 1 | Access issues this cycle |
| grant_idx | output | IDX_W (2) | Slot written by the granted access, valid with `grant` |

## Verification
Each slot's occupancy and address are internal state, so a fault there shows at the ports only through a later decision. If a slot fails to be recorded, a later conflicting access is granted when it should stall. If a release is lost, the stall never clears. If a slot is corrupted, `grant_idx` points at the wrong slot. Because of this, the stimulus always follows a grant with an access that probes the slot just written, either in the next cycle or within a few cycles. Each release strobe is likewise paired with a request that depends on it, so a corrupted slot changes `stall`, `grant` or `grant_idx` within one to three cycles of the fault.

// File: rtl/mog_pkg.sv
package mog_pkg;

   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_kind_e;

   function automatic int slot_idx_w(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/mog_entry_bank.sv
module mog_entry_bank #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [DEPTH-1:0]  release_strb,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              has_free,
   output logic [IDX_W-1:0]  free_idx
);

   logic [DEPTH-1:0]  occ_q;
   logic [DEPTH-1:0]  live;
   logic [DEPTH-1:0]  match;
   logic [ADDR_W-1:0] addr_q [DEPTH];

   // a slot released this cycle is treated as empty already
   assign live = occ_q & ~release_strb;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic take;
      assign take     = alloc && (free_idx == IDX_W'(i));
      assign match[i] = live[i] && (addr_q[i] == probe_addr);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ_q[i]  <= 1'b0;
            addr_q[i] <= '0;
         end else begin
            occ_q[i] <= take | live[i];
            if (take) begin
               addr_q[i] <= alloc_addr;
            end
         end
      end
   end

   assign probe_hit = |match;
   assign has_free  = ~&live;

   // lowest-numbered empty slot wins
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!live[i]) begin
            free_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mog_issue_arbiter.sv
module mog_issue_arbiter
   import mog_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             req_valid,
   input  acc_kind_e        kind,
   input  logic             ld_hit,
   input  logic             st_hit,
   input  logic             ld_has_free,
   input  logic             st_has_free,
   input  logic [IDX_W-1:0] ld_free_idx,
   input  logic [IDX_W-1:0] st_free_idx,
   output logic             stall,
   output logic             grant_ld,
   output logic             grant_st,
   output logic [IDX_W-1:0] grant_idx
);

   logic conflict;
   logic room;

   always_comb begin
      unique case (kind)
         ACC_LOAD: begin
            conflict  = st_hit;
            room      = ld_has_free;
            grant_idx = ld_free_idx;
         end
         ACC_STORE: begin
            conflict  = st_hit | ld_hit;
            room      = st_has_free;
            grant_idx = st_free_idx;
         end
         default: begin
            conflict  = 1'b1;
            room      = 1'b0;
            grant_idx = '0;
         end
      endcase
   end

   assign stall    = req_valid & (conflict | ~room);
   assign grant_ld = req_valid & ~stall & (kind == ACC_LOAD);
   assign grant_st = req_valid & ~stall & (kind == ACC_STORE);

endmodule

// File: rtl/mog_order_guard.sv
module mog_order_guard
   import mog_pkg::*;
#(
   parameter int LD_DEPTH = 4,
   parameter int ST_DEPTH = 4,
   parameter int ADDR_W   = 16,
   localparam int MAX_D   = (LD_DEPTH > ST_DEPTH) ? LD_DEPTH : ST_DEPTH,
   localparam int IDX_W   = slot_idx_w(MAX_D)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_is_store,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [LD_DEPTH-1:0] ld_done,
   input  logic [ST_DEPTH-1:0] st_done,
   output logic                stall,
   output logic                grant,
   output logic [IDX_W-1:0]    grant_idx
);

   if (LD_DEPTH < 1 || ST_DEPTH < 1) begin : g_bad_depth
      $error("mog_order_guard: buffer depths must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mog_order_guard: ADDR_W must be at least 1");
   end

   logic             ld_hit, st_hit;
   logic             ld_has_free, st_has_free;
   logic [IDX_W-1:0] ld_free_idx, st_free_idx;
   logic             grant_ld, grant_st;
   acc_kind_e        kind;

   assign kind = acc_kind_e'(req_is_store);

   mog_entry_bank #(
      .DEPTH (LD_DEPTH),
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W)
   ) u_ld_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (grant_ld),
      .alloc_addr  (req_addr),
      .release_strb(ld_done),
      .probe_addr  (req_addr),
      .probe_hit   (ld_hit),
      .has_free    (ld_has_free),
      .free_idx    (ld_free_idx)
   );

   mog_entry_bank #(
      .DEPTH (ST_DEPTH),
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W)
   ) u_st_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (grant_st),
      .alloc_addr  (req_addr),
      .release_strb(st_done),
      .probe_addr  (req_addr),
      .probe_hit   (st_hit),
      .has_free    (st_has_free),
      .free_idx    (st_free_idx)
   );

   mog_issue_arbiter #(
      .IDX_W(IDX_W)
   ) u_arb (
      .req_valid  (req_valid),
      .kind       (kind),
      .ld_hit     (ld_hit),
      .st_hit     (st_hit),
      .ld_has_free(ld_has_free),
      .st_has_free(st_has_free),
      .ld_free_idx(ld_free_idx),
      .st_free_idx(st_free_idx),
      .stall      (stall),
      .grant_ld   (grant_ld),
      .grant_st   (grant_st),
      .grant_idx  (grant_idx)
   );

   assign grant = grant_ld | grant_st;

endmodule

// File: rtl/mog_order_guard_chk.sv
module mog_order_guard_chk #(
   parameter int LD_DEPTH = 4,
   parameter int ST_DEPTH = 4,
   parameter int ADDR_W   = 16,
   parameter int IDX_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_is_store,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [LD_DEPTH-1:0] ld_done,
   input logic [ST_DEPTH-1:0] st_done,
   input logic                stall,
   input logic                grant,
   input logic [IDX_W-1:0]    grant_idx
);

   // shadow occupancy rebuilt from port activity only
   logic [LD_DEPTH-1:0] sh_lv;
   logic [ST_DEPTH-1:0] sh_sv;
   logic [ADDR_W-1:0]   sh_la [LD_DEPTH];
   logic [ADDR_W-1:0]   sh_sa [ST_DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_lv <= '0;
         sh_sv <= '0;
         for (int i = 0; i < LD_DEPTH; i++) sh_la[i] <= '0;
         for (int i = 0; i < ST_DEPTH; i++) sh_sa[i] <= '0;
      end else begin
         sh_lv <= sh_lv & ~ld_done;
         sh_sv <= sh_sv & ~st_done;
         if (grant && !req_is_store) begin
            sh_lv[grant_idx] <= 1'b1;
            sh_la[grant_idx] <= req_addr;
         end
         if (grant && req_is_store) begin
            sh_sv[grant_idx] <= 1'b1;
            sh_sa[grant_idx] <= req_addr;
         end
      end
   end

   logic                ld_m, st_m, ld_full, st_full;
   logic [IDX_W-1:0]    ld_low, st_low;

   always_comb begin
      ld_m = 1'b0; st_m = 1'b0;
      ld_low = '0; st_low = '0;
      for (int i = LD_DEPTH - 1; i >= 0; i--) begin
         if (sh_lv[i] && !ld_done[i] && sh_la[i] == req_addr) ld_m = 1'b1;
         if (!(sh_lv[i] && !ld_done[i])) ld_low = IDX_W'(i);
      end
      for (int i = ST_DEPTH - 1; i >= 0; i--) begin
         if (sh_sv[i] && !st_done[i] && sh_sa[i] == req_addr) st_m = 1'b1;
         if (!(sh_sv[i] && !st_done[i])) st_low = IDX_W'(i);
      end
   end

   assign ld_full = &(sh_lv & ~ld_done);
   assign st_full = &(sh_sv & ~st_done);

   a_r2_load_hits_store: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_is_store && st_m |-> stall && !grant);

   a_r4_store_hits_any: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_is_store && (st_m || ld_m) |-> stall && !grant);

   a_r5_clear_path_grants: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !st_m && (req_is_store ? (!ld_m && !st_full) : !ld_full) |-> grant);

   a_r7_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_is_store ? st_full : ld_full) |-> stall);

   a_r6_lowest_slot: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> grant_idx == (req_is_store ? st_low : ld_low));

   a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      stall && ld_done == '0 && st_done == '0 |=>
         (req_valid && $stable(req_addr) && $stable(req_is_store) &&
          ld_done == '0 && st_done == '0) |-> stall);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !stall && !grant);

endmodule

bind mog_order_guard mog_order_guard_chk #(
   .LD_DEPTH(LD_DEPTH),
   .ST_DEPTH(ST_DEPTH),
   .ADDR_W  (ADDR_W),
   .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/tb_mog_order_guard.sv
`timescale 1ns/100ps
module tb_mog_order_guard;

   localparam int LDD = 4;
   localparam int STD = 4;
   localparam int AW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_is_store = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [LDD-1:0] ld_done = '0;
   logic [STD-1:0] st_done = '0;
   logic           stall, grant;
   logic [1:0]     grant_idx;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mog_order_guard #(.LD_DEPTH(LDD), .ST_DEPTH(STD), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
      .req_addr(req_addr), .ld_done(ld_done), .st_done(st_done),
      .stall(stall), .grant(grant), .grant_idx(grant_idx)
   );

   typedef struct packed {
      logic           v;
      logic           st;
      logic [AW-1:0]  addr;
      logic [LDD-1:0] ldd;
      logic [STD-1:0] std;
      logic           e_stall;
      logic           e_grant;
      logic [1:0]     e_idx;
      logic [3:0]     req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 16'h0010, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'd1}, // R1 first load
      '{1'b1, 1'b1, 16'h0020, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'd1}, // R1 first store
      '{1'b1, 1'b0, 16'h0020, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd2}, // R2 load vs store
      '{1'b1, 1'b0, 16'h0010, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd1, 4'd5}, // R5 load vs load ok
      '{1'b1, 1'b1, 16'h0010, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd4}, // R4 store vs load
      '{1'b1, 1'b1, 16'h0020, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd4}, // R4 store vs store
      '{1'b1, 1'b1, 16'h0030, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd1, 4'd5}, // R5 clean store
      '{1'b1, 1'b0, 16'h0020, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd3}, // R3 still held
      '{1'b1, 1'b0, 16'h0020, 4'b0000, 4'b0001, 1'b0, 1'b1, 2'd2, 4'd3}, // R3 release same cycle
      '{1'b1, 1'b1, 16'h0040, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'd6}, // R6 reuse lowest
      '{1'b1, 1'b0, 16'h0050, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd3, 4'd6}, // R6 load buffer fills
      '{1'b1, 1'b0, 16'h0060, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd7}, // R7 load full
      '{1'b1, 1'b0, 16'h0060, 4'b0010, 4'b0000, 1'b0, 1'b1, 2'd1, 4'd8}, // R8 freed slot reused
      '{1'b1, 1'b1, 16'h0010, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd4}, // R4 store vs load slot 0
      '{1'b1, 1'b1, 16'h0010, 4'b0001, 4'b0000, 1'b0, 1'b1, 2'd2, 4'd3}, // R3 load release
      '{1'b0, 1'b0, 16'h0000, 4'b0000, 4'b0010, 1'b0, 1'b0, 2'd0, 4'd8}, // R8 idle strobe
      '{1'b1, 1'b1, 16'h0030, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd1, 4'd8}, // R8 slot 1 free again
      '{1'b1, 1'b1, 16'h0070, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd3, 4'd6}, // R6 store fills
      '{1'b1, 1'b1, 16'h0080, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'd7}, // R7 store full
      '{1'b1, 1'b0, 16'h0080, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'd5}  // R5 load to new addr
   };

   task automatic check(input string tag, input logic e_stall, input logic e_grant,
                        input logic [1:0] e_idx);
      checks++;
      if (stall !== e_stall || grant !== e_grant || (e_grant && grant_idx !== e_idx)) begin
         errors++;
         $display("FAIL %s: stall=%b grant=%b idx=%0d, expected stall=%b grant=%b idx=%0d",
                  tag, stall, grant, grant_idx, e_stall, e_grant, e_idx);
      end
   endtask

   task automatic drive(input logic v, input logic st, input logic [AW-1:0] a,
                        input logic [LDD-1:0] ldd, input logic [STD-1:0] sd);
      @(negedge clk);
      req_valid = v; req_is_store = st; req_addr = a; ld_done = ldd; st_done = sd;
      #1;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, '0, '0, '0);
      check("R1 idle after reset", 1'b0, 1'b0, 2'd0);

      for (int k = 0; k < NV; k++) begin
         drive(VEC[k].v, VEC[k].st, VEC[k].addr, VEC[k].ldd, VEC[k].std);
         check($sformatf("R%0d vector %0d", VEC[k].req, k),
               VEC[k].e_stall, VEC[k].e_grant, VEC[k].e_idx);
      end

      // reset while both buffers are full: everything must be empty after
      drive(1'b0, 1'b0, '0, '0, '0);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, 1'b1, 16'h0070, '0, '0);
      check("R1 store after mid-run reset", 1'b0, 1'b1, 2'd0);
      drive(1'b1, 1'b0, 16'h0099, '0, '0);
      check("R1 load after mid-run reset", 1'b0, 1'b1, 2'd0);
      drive(1'b1, 1'b0, 16'h0070, '0, '0);
      check("R2 load sees new store", 1'b1, 1'b0, 2'd0);
      drive(1'b1, 1'b1, 16'h0099, '0, '0);
      check("R4 store sees new load", 1'b1, 1'b0, 2'd0);
      drive(1'b1, 1'b1, 16'h0099, 4'b0010, '0);
      check("R8 wrong-slot release keeps stall", 1'b1, 1'b0, 2'd0);
      drive(1'b1, 1'b1, 16'h0099, 4'b0001, '0);
      check("R3 right-slot release grants", 1'b0, 1'b1, 2'd1);
      drive(1'b0, 1'b0, '0, '0, '0);
      check("R8 idle quiet", 1'b0, 1'b0, 2'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule